// File: doc/BRIEF.md
# TDM Time-Slot Route Sequencer

The block steps through two small programmable route tables, one for the receive side and one for the transmit side, in step with a serial TDM bit clock. Each table entry covers one time slot of `len + 1` bits. For its slot, an entry does four things:

- It picks which of six serial channels takes the incoming bits, or supplies the outgoing bits.
- It sets four strobe outputs.
- It can feed the transmitted bit back as received data.
- On the receive side, it can swap the roles of the two serial pins.

A frame-sync pulse restarts both tables at entry 0. A table stops at the end of an entry flagged as last, or at its final row. It stays idle until the next sync.

Software loads entries through a register-style write port into a shadow copy of each table. The sequencer walks an active copy, which is refreshed from the shadow on every frame sync. Writes made during a frame therefore take effect from the next frame.

Each entry is 16 bits wide with this layout:

| Bits | Field | Meaning |
|---|---|---|
| [2:0] | chan | Channel select |
| [3] | loop | Loopback |
| [4] | swap | Pin swap |
| [8:5] | strb | Strobe values; bit 5 is strobe 0 |
| [12:9] | len | Slot length minus one |
| [13] | last | Last entry |
| [15:14] | — | Reserved |

Channel code k in 1..6 selects channel index k-1. Codes 0 and 7 mean the slot is unused.

Top module: `tdm_slot_seq`

## Requirements
- R1: In a running receive slot whose chan is 1..6, rx_stb_o is one-hot at bit chan-1, and rx_data_o carries the selected source bit. The source is rxd_i normally, txd_i when swapped, and the transmitted bit when looping.
- R2: In a running transmit slot whose chan is 1..6, tx_req_o is one-hot at bit chan-1. The bit tx_data_i[chan-1] is driven on txd_o with txd_oe_o high.
- R3: An unused slot (chan 0 or 7) or an idle table makes no request. In such a transmit slot both output enables and both pin data outputs are low. In such a receive slot rx_stb_o and rx_data_o are 0.
- R4: When the active entry of either table has loop set, rx_data_o takes the transmitted bit of that cycle instead of a pin. The value is 0 when no channel is transmitting.
- R5: When the active receive entry has swap set, data is received from txd_i. The transmitted bit is driven on rxd_o with rxd_oe_o high, and txd_oe_o is low. The two enables are never high together.
- R6: The swap bit of a transmit entry has no effect on the pins.
- R7: While a table runs, its entry's strb bits appear active high on strb_o[3:0]. Any combination may be high at once.
- R8: Once a last-flagged entry, or row DEPTH-1, finishes, that table stops. Its strobes and requests go low until the next sync.
- R9: strb_o is the bitwise OR of the strobe fields of both running tables.
- R10: A fsync_i sampled high sets both tables to entry 0, bit 0, running, from the next clock. This also applies mid-table.
- R11: A write to an entry changes the walked table only from the next frame sync. A write in the same cycle as a sync also waits one more frame.
- R12: Reserved bits [15:14] are stored as zero and read back as zero on rd_data_o. Reads return the shadow contents of the table selected by rd_tbl_i.
- R13: Each entry lasts exactly len+1 bit clocks before the next entry begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fsync_i | input | 1 | Frame sync, restarts both tables |
| wr_en_i | input | 1 | Entry write strobe |
| wr_tbl_i | input | 1 | Write target: 0 receive, 1 transmit |
| wr_addr_i | input | 4 | Entry index to write |
| wr_data_i | input | 16 | Entry value |
| rd_tbl_i | input | 1 | Read table select |
| rd_addr_i | input | 4 | Entry index to read |
| rd_data_o | output | 16 | Shadow entry contents |
| rxd_i | input | 1 | Receive pin input |
| txd_i | input | 1 | Transmit pin input, used when swapped |
| txd_o | output | 1 | Transmit pin data |
| txd_oe_o | output | 1 | Transmit pin output enable |
| rxd_o | output | 1 | Receive pin data, used when swapped |
| rxd_oe_o | output | 1 | Receive pin output enable |
| rx_stb_o | output | 6 | Per-channel receive bit strobe |
| rx_data_o | output | 1 | Received bit for the strobed channel |
| tx_req_o | output | 6 | Per-channel transmit bit request |
| tx_data_i | input | 6 | Per-channel transmit bit |
| strb_o | output | 4 | Slot strobes |

## Verification
The bench targets several corner cases, each with the failure it would expose:

- **Mid-table sync.** A pointer that is not cleared would resume at a stale entry.
- **Write during a running frame.** A single-copy table would reroute the current frame mid-way.
- **Final entry.** Strobes that are not negated would stay high through the idle gap.
- **Transmit-side swap bit.** A design that honours it would move the output enable to the wrong pin.

The bench also covers loop combined with swap, where the loop source must win, and overlapping strobes from both tables, which must be ORed rather than overwritten. Slots of more than one bit catch an off-by-one in slot length, which would shift every later route by a clock.

// File: rtl/tdm_seq_pkg.sv
package tdm_seq_pkg;
  localparam int ENT_W  = 16;
  localparam int CSEL_W = 3;
  localparam int CNT_W  = 4;
  localparam int STB_N  = 4;
  localparam int CH_N   = 6;
  localparam int RSV_W  = ENT_W - CSEL_W - CNT_W - STB_N - 3;

  typedef struct packed {
    logic [RSV_W-1:0]  rsvd;
    logic              last;
    logic [CNT_W-1:0]  len;
    logic [STB_N-1:0]  strb;
    logic              swap;
    logic              loop;
    logic [CSEL_W-1:0] chan;
  } slot_ent_t;

  function automatic logic chan_used(logic [CSEL_W-1:0] c);
    return (c != '0) && (c != '1);
  endfunction

  function automatic logic [CH_N-1:0] chan_onehot(logic [CSEL_W-1:0] c);
    logic [CH_N-1:0] r;
    r = '0;
    if (chan_used(c)) r[c - CSEL_W'(1)] = 1'b1;
    return r;
  endfunction

  function automatic slot_ent_t scrub(slot_ent_t e);
    slot_ent_t r;
    r      = e;
    r.rsvd = '0;
    return r;
  endfunction
endpackage

// File: rtl/tdm_route_tbl.sv
module tdm_route_tbl
  import tdm_seq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  slot_ent_t     wr_data_i,
  input  logic          load_i,
  input  logic [AW-1:0] cur_addr_i,
  output slot_ent_t     cur_o,
  input  logic [AW-1:0] rd_addr_i,
  output slot_ent_t     rd_o
);
  slot_ent_t shadow_q [DEPTH];
  slot_ent_t active_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        shadow_q[i] <= '0;
        active_q[i] <= '0;
      end
    end else begin
      // active copy takes the shadow as it stood before this edge's write
      if (load_i) active_q <= shadow_q;
      if (wr_en_i) shadow_q[wr_addr_i] <= scrub(wr_data_i);
    end
  end

  assign cur_o = active_q[cur_addr_i];
  assign rd_o  = shadow_q[rd_addr_i];

  // R11
  active_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i ##1 $stable(cur_addr_i) |-> $stable(cur_o));
endmodule

// File: rtl/tdm_slot_walker.sv
module tdm_slot_walker
  import tdm_seq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sync_i,
  input  slot_ent_t     ent_i,
  output logic [AW-1:0] ptr_o,
  output logic          run_o
);
  logic             run_q;
  logic [AW-1:0]    ptr_q;
  logic [CNT_W-1:0] bit_q;
  logic             slot_end, tbl_end;

  assign slot_end = (bit_q == ent_i.len);
  assign tbl_end  = ent_i.last || (ptr_q == AW'(DEPTH - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      ptr_q <= '0;
      bit_q <= '0;
    end else if (sync_i) begin
      run_q <= 1'b1;
      ptr_q <= '0;
      bit_q <= '0;
    end else if (run_q) begin
      if (slot_end) begin
        bit_q <= '0;
        if (tbl_end) run_q <= 1'b0;
        else         ptr_q <= ptr_q + AW'(1);
      end else begin
        bit_q <= bit_q + CNT_W'(1);
      end
    end
  end

  assign ptr_o = ptr_q;
  assign run_o = run_q;

  // R10
  sync_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> run_q && ptr_q == '0 && bit_q == '0);

  // R13
  slot_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && !sync_i && !slot_end |=> bit_q == $past(bit_q) + CNT_W'(1) && ptr_q == $past(ptr_q));

  // R8
  last_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && !sync_i && slot_end && ent_i.last |=> !run_q);
endmodule

// File: rtl/tdm_pin_mux.sv
module tdm_pin_mux
  import tdm_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_run_i,
  input  slot_ent_t        rx_ent_i,
  input  logic             tx_run_i,
  input  slot_ent_t        tx_ent_i,
  input  logic [CH_N-1:0]  tx_data_i,
  input  logic             rxd_i,
  input  logic             txd_i,
  output logic             txd_o,
  output logic             txd_oe_o,
  output logic             rxd_o,
  output logic             rxd_oe_o,
  output logic [CH_N-1:0]  rx_stb_o,
  output logic             rx_data_o,
  output logic [CH_N-1:0]  tx_req_o,
  output logic [STB_N-1:0] strb_o
);
  logic swap, loop, tx_used, rx_used, tx_bit, rx_src;

  always_comb begin
    swap    = rx_run_i && rx_ent_i.swap;  // transmit-side swap bit deliberately unused
    loop    = (rx_run_i && rx_ent_i.loop) || (tx_run_i && tx_ent_i.loop);
    tx_used = tx_run_i && chan_used(tx_ent_i.chan);
    rx_used = rx_run_i && chan_used(rx_ent_i.chan);
    tx_bit  = tx_used ? tx_data_i[tx_ent_i.chan - CSEL_W'(1)] : 1'b0;

    if (loop)      rx_src = tx_bit;
    else if (swap) rx_src = txd_i;
    else           rx_src = rxd_i;

    txd_oe_o  = tx_used && !swap;
    rxd_oe_o  = tx_used && swap;
    txd_o     = txd_oe_o ? tx_bit : 1'b0;
    rxd_o     = rxd_oe_o ? tx_bit : 1'b0;
    tx_req_o  = tx_run_i ? chan_onehot(tx_ent_i.chan) : '0;
    rx_stb_o  = rx_run_i ? chan_onehot(rx_ent_i.chan) : '0;
    rx_data_o = rx_used ? rx_src : 1'b0;
    strb_o    = (rx_run_i ? rx_ent_i.strb : '0) | (tx_run_i ? tx_ent_i.strb : '0);
  end

  // R5
  one_driver_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(txd_oe_o && rxd_oe_o));

  // R1
  rx_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rx_stb_o) && $onehot0(tx_req_o));

  // R3
  unused_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o == '0 |-> !txd_oe_o && !rxd_oe_o);

  // R9
  strb_or_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_run_i |-> (strb_o & rx_ent_i.strb) == rx_ent_i.strb);
endmodule

// File: rtl/tdm_slot_seq.sv
module tdm_slot_seq
  import tdm_seq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fsync_i,
  input  logic             wr_en_i,
  input  logic             wr_tbl_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [ENT_W-1:0] wr_data_i,
  input  logic             rd_tbl_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [ENT_W-1:0] rd_data_o,
  input  logic             rxd_i,
  input  logic             txd_i,
  output logic             txd_o,
  output logic             txd_oe_o,
  output logic             rxd_o,
  output logic             rxd_oe_o,
  output logic [CH_N-1:0]  rx_stb_o,
  output logic             rx_data_o,
  output logic [CH_N-1:0]  tx_req_o,
  input  logic [CH_N-1:0]  tx_data_i,
  output logic [STB_N-1:0] strb_o
);
  localparam int NTBL = 2;  // 0 receive, 1 transmit

  slot_ent_t [NTBL-1:0]         cur_ent;
  slot_ent_t [NTBL-1:0]         rd_ent;
  logic      [NTBL-1:0][AW-1:0] ptr;
  logic      [NTBL-1:0]         run;

  for (genvar t = 0; t < NTBL; t++) begin : g_side
    tdm_route_tbl #(.DEPTH(DEPTH)) u_tbl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (wr_en_i && (wr_tbl_i == 1'(t))),
      .wr_addr_i  (wr_addr_i),
      .wr_data_i  (slot_ent_t'(wr_data_i)),
      .load_i     (fsync_i),
      .cur_addr_i (ptr[t]),
      .cur_o      (cur_ent[t]),
      .rd_addr_i  (rd_addr_i),
      .rd_o       (rd_ent[t])
    );

    tdm_slot_walker #(.DEPTH(DEPTH)) u_walk (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sync_i (fsync_i),
      .ent_i  (cur_ent[t]),
      .ptr_o  (ptr[t]),
      .run_o  (run[t])
    );
  end

  assign rd_data_o = rd_ent[rd_tbl_i];

  tdm_pin_mux u_mux (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rx_run_i  (run[0]),
    .rx_ent_i  (cur_ent[0]),
    .tx_run_i  (run[1]),
    .tx_ent_i  (cur_ent[1]),
    .tx_data_i (tx_data_i),
    .rxd_i     (rxd_i),
    .txd_i     (txd_i),
    .txd_o     (txd_o),
    .txd_oe_o  (txd_oe_o),
    .rxd_o     (rxd_o),
    .rxd_oe_o  (rxd_oe_o),
    .rx_stb_o  (rx_stb_o),
    .rx_data_o (rx_data_o),
    .tx_req_o  (tx_req_o),
    .strb_o    (strb_o)
  );

  // R12
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[ENT_W-1 -: RSV_W] == '0);
endmodule

// File: tb/tdm_slot_seq_tb_top.sv
`timescale 1ns/1ps
module tdm_slot_seq_tb_top;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fsync = 1'b0, wr_en = 1'b0, wr_tbl = 1'b0, rd_tbl = 1'b0;
  logic [3:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic        rxd = 1'b0, txd_in = 1'b0;
  logic [5:0]  tx_data = '0;
  logic [15:0] rd_data;
  logic        txd_o, txd_oe, rxd_o, rxd_oe, rx_data;
  logic [5:0]  rx_stb, tx_req;
  logic [3:0]  strb;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [15:0] m_sh [2][DEPTH];
  logic [15:0] m_act [2][DEPTH];
  bit m_run [2];
  int m_ptr [2], m_bit [2];
  bit dirty [2];
  bit sync_last;

  always #2 clk = ~clk;

  tdm_slot_seq #(.DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fsync_i(fsync),
    .wr_en_i(wr_en), .wr_tbl_i(wr_tbl), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_tbl_i(rd_tbl), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .rxd_i(rxd), .txd_i(txd_in), .txd_o(txd_o), .txd_oe_o(txd_oe),
    .rxd_o(rxd_o), .rxd_oe_o(rxd_oe), .rx_stb_o(rx_stb), .rx_data_o(rx_data),
    .tx_req_o(tx_req), .tx_data_i(tx_data), .strb_o(strb)
  );

  function automatic bit used(logic [2:0] c);
    return c != 3'd0 && c != 3'd7;
  endfunction

  function automatic logic [5:0] oh(logic [2:0] c);
    return used(c) ? 6'(1) << (c - 3'd1) : 6'd0;
  endfunction

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_outputs();
    logic [15:0] er, et;
    bit sw, lp, txu, rxu, txb, src;
    string ts, tr, tt;
    er  = m_run[0] ? m_act[0][m_ptr[0]] : 16'h0;
    et  = m_run[1] ? m_act[1][m_ptr[1]] : 16'h0;
    sw  = m_run[0] && er[4];
    lp  = (m_run[0] && er[3]) || (m_run[1] && et[3]);
    txu = m_run[1] && used(et[2:0]);
    rxu = m_run[0] && used(er[2:0]);
    txb = txu ? tx_data[et[2:0] - 3'd1] : 1'b0;
    src = lp ? txb : (sw ? txd_in : rxd);
    ts = sync_last ? "R10" : (!m_run[0] && !m_run[1]) ? "R8" : (m_run[0] && m_run[1]) ? "R9" : "R7";
    tr = lp ? "R4" : sw ? "R5" : !rxu ? "R3" : dirty[0] ? "R11" : (m_bit[0] > 0) ? "R13" : "R1";
    tt = (m_run[1] && et[4] && !sw) ? "R6" : sw ? "R5" : !txu ? "R3" : dirty[1] ? "R11" : "R2";
    chk(ts, "strb", 16'(strb), 16'((m_run[0] ? er[8:5] : 4'h0) | (m_run[1] ? et[8:5] : 4'h0)));
    chk(tr, "rx_stb", 16'(rx_stb), 16'(m_run[0] ? oh(er[2:0]) : 6'h0));
    chk(tr, "rx_data", 16'(rx_data), 16'(rxu ? src : 1'b0));
    chk(tt, "tx_req", 16'(tx_req), 16'(m_run[1] ? oh(et[2:0]) : 6'h0));
    chk(tt, "pins", {12'h0, txd_oe, txd_o, rxd_oe, rxd_o},
        {12'h0, txu && !sw, txu && !sw && txb, txu && sw, txu && sw && txb});
    chk("R12", "rd_data", rd_data, m_sh[rd_tbl][rd_addr]);
  endtask

  task automatic model_update(bit s, bit we, bit wt, int wa, logic [15:0] wd);
    logic [15:0] e;
    sync_last = s;
    for (int t = 0; t < 2; t++) begin
      e = m_act[t][m_ptr[t]];
      if (s) begin
        m_act[t] = m_sh[t];
        m_run[t] = 1; m_ptr[t] = 0; m_bit[t] = 0; dirty[t] = 0;
      end else if (m_run[t]) begin
        if (m_bit[t] == int'(e[12:9])) begin
          m_bit[t] = 0;
          if (e[13] || m_ptr[t] == DEPTH - 1) m_run[t] = 0;
          else m_ptr[t]++;
        end else m_bit[t]++;
      end
    end
    if (we) begin
      m_sh[wt][wa] = wd & 16'h3FFF;
      if (m_run[wt] && !s) dirty[wt] = 1;
    end
  endtask

  task automatic cyc(bit s, bit we, bit wt, int wa, logic [15:0] wd);
    fsync = s; wr_en = we; wr_tbl = wt; wr_addr = 4'(wa); wr_data = wd;
    tx_data = 6'($urandom); rxd = 1'($urandom); txd_in = 1'($urandom);
    rd_tbl = 1'($urandom); rd_addr = 4'($urandom);
    #1 check_outputs();
    @(posedge clk);
    model_update(s, we, wt, wa, wd);
    @(negedge clk);
  endtask

  function automatic logic [15:0] ent(bit last, int len, logic [3:0] st, bit sw, bit lp, logic [2:0] ch);
    return {2'b00, last, 4'(len), st, sw, lp, ch};
  endfunction

  initial begin
    #(4ns * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] wd;
    void'($urandom(32'd7117));
    for (int t = 0; t < 2; t++) begin
      m_run[t] = 0; m_ptr[t] = 0; m_bit[t] = 0; dirty[t] = 0;
      for (int i = 0; i < DEPTH; i++) begin m_sh[t][i] = '0; m_act[t][i] = '0; end
    end
    sync_last = 0;
    repeat (3) @(negedge clk);
    // reset state: idle, nothing driven (R8)
    #1 chk("R8", "reset strb", 16'(strb), 16'h0);
    chk("R3", "reset oe", {14'h0, txd_oe, rxd_oe}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R12: reserved bits scrubbed
    cyc(0, 1, 0, 5, 16'hFFFF);
    rd_tbl = 0; rd_addr = 4'd5; #1;
    chk("R12", "rsvd readback", rd_data, 16'h3FFF);

    // directed frame: multi-bit slots, swap, loop, overlapping strobes, tx swap ignored
    cyc(0, 1, 0, 0, ent(0, 1, 4'b0001, 0, 0, 3'd1));
    cyc(0, 1, 0, 1, ent(0, 0, 4'b0011, 1, 0, 3'd5));
    cyc(0, 1, 0, 2, ent(0, 2, 4'b0000, 0, 1, 3'd6));
    cyc(0, 1, 0, 3, ent(1, 1, 4'b1000, 0, 0, 3'd0));
    cyc(0, 1, 1, 0, ent(0, 2, 4'b0100, 1, 0, 3'd2));
    cyc(0, 1, 1, 1, ent(0, 0, 4'b0001, 0, 0, 3'd7));
    cyc(0, 1, 1, 2, ent(1, 3, 4'b0010, 1, 1, 3'd4));
    cyc(1, 0, 0, 0, '0);
    cyc(0, 1, 0, 3, ent(1, 3, 4'b1111, 0, 0, 3'd3));  // mid-frame write
    repeat (14) cyc(0, 0, 0, 0, '0);
    cyc(1, 0, 0, 0, '0);
    repeat (4) cyc(0, 0, 0, 0, '0);
    cyc(1, 0, 0, 0, '0);  // mid-table restart
    repeat (16) cyc(0, 0, 0, 0, '0);

    // random phase
    for (int n = 0; n < 8000; n++) begin
      wd = 16'($urandom);
      wd[12:9] = {2'b00, wd[10:9]};
      wd[13] = ($urandom % 5) == 0;
      cyc(($urandom % 30) == 0, ($urandom % 6) == 0, 1'($urandom), int'($urandom % DEPTH), wd);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule